// File: doc/BRIEF.md
# Node Communication State Controller

This block holds the communication state of a field-bus node. The state changes only when the master writes a requested state. A write strobe carries a 4-bit requested-state code, an error-acknowledge bit, and a configuration-valid flag that the node supplies. From the current state the block derives four enables: mailbox, input process data, output-data acceptance and output drive. Until the node is fully operational, the physical output word is held at a safe constant.

Requests that the transition graph does not permit are rejected. A rejected request leaves the state as it is, raises an error flag and latches a status code. While the error flag is up, the block refuses any move to a higher state. Moves to lower states are still taken. Writing the acknowledge bit together with a request clears the flag. A fault event always raises the error flag. A fault that arrives while the node is fully operational also forces the node back to the safe-running state.

The firmware-update branch can be entered only from the initial state and can only return to it.

Top module: `node_state_ctrl`

## Requirements
- R1: After reset the state code is 1 (initial state), the error flag is 0 and the status code is 8'h00.
- R2: The state codes are: initial 1, mailbox-only 2, update 3, safe-running 4, fully operational 8. Enables follow the state as below, with every other enable 0:
  - initial: all enables 0.
  - mailbox-only and update: mailbox only.
  - safe-running: mailbox, input and output-accept.
  - fully operational: all four enables, output drive included.
- R3: Outside the fully operational state, out_data_o equals SAFE_VAL. In that state, out_data_o follows out_data_i.
- R4: The legal moves are:
  - initial and mailbox-only, in both directions.
  - mailbox-only and safe-running, in both directions.
  - safe-running to fully operational.
  - fully operational to safe-running, mailbox-only or initial.
  - initial and update, in both directions.
- R5: A write that requests an illegal move, or an undefined code, leaves the state unchanged. It sets the error flag and sets the status code to 8'h11. A write that requests the current state changes nothing.
- R6: A move from mailbox-only to safe-running while cfg_valid_i is 0 is refused. The state stays mailbox-only, the error flag is set and the status code becomes 8'h12.
- R7: A fault in the fully operational state moves the node to safe-running. A fault in any state sets the error flag and sets the status code to 8'h1A. A fault takes priority over a write in the same cycle.
- R8: While the error flag is set, a legal upward move without acknowledge is ignored. Upward means into the update, mailbox-only, safe-running or fully operational state from a lower one. Nothing changes. A downward move is taken, and the error flag stays set.
- R9: A write with err_ack_i set clears the error flag and resets the status code to 8'h00. The request in the same write is then judged as if no error had been pending.
- R10: Without a write strobe and without a fault, nothing changes, whatever the request inputs carry.
- R11: Every change in registered state appears at the outputs one clock after the edge that samples the write or fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_wr_i | input | 1 | Requested-state write strobe |
| req_state_i | input | 4 | Requested state code |
| err_ack_i | input | 1 | Error acknowledge, sampled with the write |
| cfg_valid_i | input | 1 | Configuration is valid |
| fault_i | input | 1 | Error event |
| out_data_i | input | OUT_W | Output word from the master |
| state_o | output | 4 | Current state code |
| err_o | output | 1 | Error flag |
| err_code_o | output | CODE_W | Latched status code |
| mbx_en_o | output | 1 | Mailbox enable |
| in_en_o | output | 1 | Input process data enable |
| out_acc_o | output | 1 | Output data accepted |
| out_drv_o | output | 1 | Physical outputs driven |
| out_data_o | output | OUT_W | Physical output word |

## Verification
The bench walks the node through every legal edge of the graph. It also tries the illegal ones: mailbox-only to fully operational, update to mailbox-only, and an undefined code. A design with a loose graph would change state on these and leave the error flag low.

The bench then checks the gating behaviour:
- A raised error must block upward moves but not downward ones. A design that gates every move would get stuck, and one that ignores the error would climb.
- The acknowledge must clear the flag and let the same write proceed.
- A fault must win over a simultaneous write.
- Output drive and the safe word are compared in the safe-running state, where a design that merged input and output enabling would leak the master's data.

// File: rtl/node_state_pkg.sv
package node_state_pkg;

  typedef enum logic [3:0] {
    ST_INIT   = 4'h1,
    ST_PREOP  = 4'h2,
    ST_BOOT   = 4'h3,
    ST_SAFEOP = 4'h4,
    ST_OP     = 4'h8
  } node_st_e;

  localparam logic [7:0] CODE_NONE  = 8'h00;
  localparam logic [7:0] CODE_BAD   = 8'h11;
  localparam logic [7:0] CODE_CFG   = 8'h12;
  localparam logic [7:0] CODE_FAULT = 8'h1A;

  // ordering used to decide whether a move goes upward
  function automatic logic [1:0] st_rank(input logic [3:0] s);
    case (s)
      ST_INIT:           st_rank = 2'd0;
      ST_PREOP, ST_BOOT: st_rank = 2'd1;
      ST_SAFEOP:         st_rank = 2'd2;
      default:           st_rank = 2'd3;
    endcase
  endfunction

  function automatic logic edge_ok(input logic [3:0] cur, input logic [3:0] nxt);
    case (cur)
      ST_INIT:   edge_ok = (nxt == ST_PREOP) || (nxt == ST_BOOT);
      ST_PREOP:  edge_ok = (nxt == ST_INIT) || (nxt == ST_SAFEOP);
      ST_BOOT:   edge_ok = (nxt == ST_INIT);
      ST_SAFEOP: edge_ok = (nxt == ST_PREOP) || (nxt == ST_OP);
      ST_OP:     edge_ok = (nxt == ST_SAFEOP) || (nxt == ST_PREOP) || (nxt == ST_INIT);
      default:   edge_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/node_trans_check.sv
module node_trans_check
  import node_state_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [3:0]        cur_i,
  input  logic [3:0]        req_i,
  input  logic              cfg_valid_i,
  input  logic              err_pend_i,
  output logic              take_o,
  output logic              set_err_o,
  output logic [CODE_W-1:0] code_o
);

  logic upward;
  assign upward = st_rank(req_i) > st_rank(cur_i);

  always_comb begin
    take_o    = 1'b0;
    set_err_o = 1'b0;
    code_o    = CODE_W'(CODE_NONE);
    if (req_i == cur_i) begin
      take_o = 1'b0;
    end else if (!edge_ok(cur_i, req_i)) begin
      set_err_o = 1'b1;
      code_o    = CODE_W'(CODE_BAD);
    end else if (upward && err_pend_i) begin
      take_o = 1'b0;
    end else if (cur_i == ST_PREOP && req_i == ST_SAFEOP && !cfg_valid_i) begin
      set_err_o = 1'b1;
      code_o    = CODE_W'(CODE_CFG);
    end else begin
      take_o = 1'b1;
    end
  end

  always_comb begin
    if (take_o) a_r4_take_legal: assert (edge_ok(cur_i, req_i));
  end

endmodule

// File: rtl/node_state_reg.sv
module node_state_reg
  import node_state_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              ack_i,
  input  logic              fault_i,
  input  logic              cfg_valid_i,
  input  logic [3:0]        nxt_i,
  input  logic              take_i,
  input  logic              set_err_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [3:0]        state_o,
  output logic              err_o,
  output logic              err_pend_o,
  output logic [CODE_W-1:0] code_o
);

  logic [3:0]        state_q;
  logic              err_q;
  logic [CODE_W-1:0] code_q;

  assign err_pend_o = err_q && !(wr_i && ack_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      err_q   <= 1'b0;
      code_q  <= CODE_W'(CODE_NONE);
    end else if (fault_i) begin
      err_q  <= 1'b1;
      code_q <= CODE_W'(CODE_FAULT);
      if (state_q == ST_OP) state_q <= ST_SAFEOP;
    end else if (wr_i) begin
      if (set_err_i) begin
        err_q  <= 1'b1;
        code_q <= code_i;
      end else if (ack_i) begin
        err_q  <= 1'b0;
        code_q <= CODE_W'(CODE_NONE);
      end
      if (take_i) state_q <= nxt_i;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
  assign code_o  = code_q;

  a_r7_fault_in_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && state_q == ST_OP) |=> (state_q == ST_SAFEOP && err_q));

  a_r4_boot_only_from_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BOOT && $past(state_q) != ST_BOOT) |-> $past(state_q) == ST_INIT);

  a_r6_cfg_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_i && state_q == ST_PREOP && !cfg_valid_i) |=> state_q != ST_SAFEOP);

  a_r8_no_climb_with_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_i && ack_i)) |=> st_rank(state_q) <= st_rank($past(state_q)));

  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !fault_i) |=> ($stable(state_q) && $stable(err_q) && $stable(code_q)));

endmodule

// File: rtl/node_out_gate.sv
module node_out_gate
  import node_state_pkg::*;
#(
  parameter int              OUT_W    = 16,
  parameter logic [OUT_W-1:0] SAFE_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       state_i,
  input  logic [OUT_W-1:0] data_i,
  output logic             mbx_en_o,
  output logic             in_en_o,
  output logic             out_acc_o,
  output logic             out_drv_o,
  output logic [OUT_W-1:0] data_o
);

  always_comb begin
    mbx_en_o  = 1'b0;
    in_en_o   = 1'b0;
    out_acc_o = 1'b0;
    out_drv_o = 1'b0;
    case (state_i)
      ST_PREOP, ST_BOOT: mbx_en_o = 1'b1;
      ST_SAFEOP: begin
        mbx_en_o  = 1'b1;
        in_en_o   = 1'b1;
        out_acc_o = 1'b1;
      end
      ST_OP: begin
        mbx_en_o  = 1'b1;
        in_en_o   = 1'b1;
        out_acc_o = 1'b1;
        out_drv_o = 1'b1;
      end
      default: ;
    endcase
  end

  // per-bit hold to the safe value
  for (genvar b = 0; b < OUT_W; b++) begin : g_hold
    assign data_o[b] = out_drv_o ? data_i[b] : SAFE_VAL[b];
  end

  a_r3_safe_outside_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_OP) |-> data_o == SAFE_VAL);

  a_r2_drive_implies_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_drv_o |-> (out_acc_o && in_en_o && mbx_en_o));

endmodule

// File: rtl/node_state_ctrl.sv
module node_state_ctrl
  import node_state_pkg::*;
#(
  parameter int               OUT_W    = 16,
  parameter int               CODE_W   = 8,
  parameter logic [OUT_W-1:0] SAFE_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_wr_i,
  input  logic [3:0]        req_state_i,
  input  logic              err_ack_i,
  input  logic              cfg_valid_i,
  input  logic              fault_i,
  input  logic [OUT_W-1:0]  out_data_i,
  output logic [3:0]        state_o,
  output logic              err_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic              mbx_en_o,
  output logic              in_en_o,
  output logic              out_acc_o,
  output logic              out_drv_o,
  output logic [OUT_W-1:0]  out_data_o
);

  logic [3:0]        cur;
  logic              err_pend;
  logic              take;
  logic              set_err;
  logic [CODE_W-1:0] chk_code;

  node_trans_check #(.CODE_W(CODE_W)) u_chk (
    .cur_i      (cur),
    .req_i      (req_state_i),
    .cfg_valid_i(cfg_valid_i),
    .err_pend_i (err_pend),
    .take_o     (take),
    .set_err_o  (set_err),
    .code_o     (chk_code)
  );

  node_state_reg #(.CODE_W(CODE_W)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (req_wr_i),
    .ack_i      (err_ack_i),
    .fault_i    (fault_i),
    .cfg_valid_i(cfg_valid_i),
    .nxt_i      (req_state_i),
    .take_i     (take),
    .set_err_i  (set_err),
    .code_i     (chk_code),
    .state_o    (cur),
    .err_o      (err_o),
    .err_pend_o (err_pend),
    .code_o     (err_code_o)
  );

  node_out_gate #(.OUT_W(OUT_W), .SAFE_VAL(SAFE_VAL)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (cur),
    .data_i   (out_data_i),
    .mbx_en_o (mbx_en_o),
    .in_en_o  (in_en_o),
    .out_acc_o(out_acc_o),
    .out_drv_o(out_drv_o),
    .data_o   (out_data_o)
  );

  assign state_o = cur;

  a_r5_bad_code_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && !fault_i && !edge_ok(state_o, req_state_i) && req_state_i != state_o)
    |=> ($stable(state_o) && err_o && err_code_o == CODE_W'(CODE_BAD)));

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wr_i && err_ack_i && !fault_i && req_state_i == state_o) |=> !err_o);

endmodule

// File: tb/sim_node_state_ctrl.sv
module sim_node_state_ctrl;
  localparam int OUT_W = 16;
  localparam int CODE_W = 8;
  localparam logic [OUT_W-1:0] SAFE = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wr = 1'b0, ack = 1'b0, cfg = 1'b0, fault = 1'b0;
  logic [3:0] req_st = 4'h0;
  logic [OUT_W-1:0] din = 16'hBEEF;
  logic [3:0] state;
  logic err, mbx, inen, acc, drv;
  logic [CODE_W-1:0] code;
  logic [OUT_W-1:0] dout;

  always #4 clk = ~clk;

  node_state_ctrl #(.OUT_W(OUT_W), .CODE_W(CODE_W), .SAFE_VAL(SAFE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_wr_i(req_wr), .req_state_i(req_st),
    .err_ack_i(ack), .cfg_valid_i(cfg), .fault_i(fault), .out_data_i(din),
    .state_o(state), .err_o(err), .err_code_o(code), .mbx_en_o(mbx),
    .in_en_o(inen), .out_acc_o(acc), .out_drv_o(drv), .out_data_o(dout)
  );

  typedef struct {
    string       tag;
    logic [32:0] v;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected vector from the requirement tables (R2, R3)
  function automatic logic [32:0] mk(input logic [3:0] s, input logic e,
                                     input logic [7:0] c, input logic [15:0] d);
    logic m, i, a, r;
    m = (s == 4'h2) || (s == 4'h3) || (s == 4'h4) || (s == 4'h8);
    i = (s == 4'h4) || (s == 4'h8);
    a = i;
    r = (s == 4'h8);
    mk = {s, e, c, m, i, a, r, (r ? d : SAFE)};
  endfunction

  function automatic logic [32:0] act();
    act = {state, err, code, mbx, inen, acc, drv, dout};
  endfunction

  task automatic step(input logic w, input logic [3:0] s, input logic a_, input logic c_,
                      input logic f, input logic [3:0] es, input logic ee,
                      input logic [7:0] ec, input string tag);
    exp_t x;
    @(negedge clk);
    req_wr = w; req_st = s; ack = a_; cfg = c_; fault = f;
    x.tag = tag;
    x.v = mk(es, ee, ec, din);
    sb.push_back(x);
    @(posedge clk);
    @(negedge clk);
    req_wr = 1'b0; ack = 1'b0; fault = 1'b0;
  endtask

  // monitor: compare one item per edge after outputs settle
  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t x;
      #2;
      x = sb.pop_front();
      checks++;
      if (act() !== x.v) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", x.tag, act(), x.v);
      end
    end
  end

  initial begin
    #20;
    checks++;
    if ({state, err, code, drv, dout} !== {4'h1, 1'b0, 8'h00, 1'b0, SAFE}) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=%h", {state, err, code, drv, dout},
               {4'h1, 1'b0, 8'h00, 1'b0, SAFE});
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 4'h8, 0, 1, 0, 4'h1, 0, 8'h00, "R10 idle after reset R1");
    step(1, 4'h2, 0, 0, 0, 4'h2, 0, 8'h00, "R4 init to preop R11");
    step(1, 4'h8, 0, 1, 0, 4'h2, 1, 8'h11, "R5 preop to op illegal");
    step(1, 4'h4, 0, 1, 0, 4'h2, 1, 8'h11, "R8 climb blocked by error");
    step(1, 4'h4, 1, 0, 0, 4'h2, 1, 8'h12, "R6 cfg invalid");
    step(1, 4'h4, 1, 1, 0, 4'h4, 0, 8'h00, "R9 ack then safeop R2");
    step(0, 4'h1, 1, 1, 0, 4'h4, 0, 8'h00, "R10 no strobe ignored");
    step(1, 4'h8, 0, 1, 0, 4'h8, 0, 8'h00, "R4 safeop to op R3");
    din = 16'h1234;
    step(0, 4'h0, 0, 1, 0, 4'h8, 0, 8'h00, "R3 op follows data");
    step(1, 4'h1, 0, 1, 1, 4'h4, 1, 8'h1A, "R7 fault in op wins over write");
    step(1, 4'h8, 0, 1, 0, 4'h4, 1, 8'h1A, "R8 op refused while error");
    step(1, 4'h2, 0, 1, 0, 4'h2, 1, 8'h1A, "R8 downward taken with error");
    step(1, 4'h4, 1, 1, 0, 4'h4, 0, 8'h00, "R9 ack and climb");
    step(1, 4'h8, 0, 1, 0, 4'h8, 0, 8'h00, "R4 to op again");
    step(1, 4'h2, 0, 1, 0, 4'h2, 0, 8'h00, "R4 op to preop");
    step(1, 4'h4, 0, 1, 0, 4'h4, 0, 8'h00, "R4 preop to safeop");
    step(1, 4'h8, 0, 1, 0, 4'h8, 0, 8'h00, "R4 safeop to op");
    step(1, 4'h4, 0, 1, 0, 4'h4, 0, 8'h00, "R4 op to safeop");
    step(1, 4'h2, 0, 1, 0, 4'h2, 0, 8'h00, "R4 safeop to preop");
    step(1, 4'h1, 0, 1, 0, 4'h1, 0, 8'h00, "R4 preop to init");
    step(1, 4'h3, 0, 1, 0, 4'h3, 0, 8'h00, "R4 init to boot R2");
    step(1, 4'h2, 0, 1, 0, 4'h3, 1, 8'h11, "R5 boot to preop illegal");
    step(1, 4'h1, 1, 1, 0, 4'h1, 0, 8'h00, "R4 boot to init with ack");
    step(1, 4'h5, 0, 1, 0, 4'h1, 1, 8'h11, "R5 undefined code");
    step(1, 4'h1, 1, 1, 0, 4'h1, 0, 8'h00, "R9 ack with same state R5");
    step(0, 4'h0, 0, 1, 1, 4'h1, 1, 8'h1A, "R7 fault in init");
    step(1, 4'h3, 0, 1, 0, 4'h1, 1, 8'h1A, "R8 boot blocked by error");
    step(1, 4'h2, 1, 1, 0, 4'h2, 0, 8'h00, "R9 ack and preop");
    step(1, 4'h4, 0, 1, 0, 4'h4, 0, 8'h00, "R4 safeop");
    step(1, 4'h8, 0, 1, 0, 4'h8, 0, 8'h00, "R4 op");
    step(1, 4'h1, 0, 1, 0, 4'h1, 0, 8'h00, "R4 op to init");
    repeat (4) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule